// File: doc/BRIEF.md
# I2C-Controlled DAC Code Register

This block is a synchronous I2C target for a single voltage-output DAC. It samples SCL and SDA with the faster system clock, finds start and stop conditions, and compares a 7-bit address against the fixed prefix `00011` followed by two strap bits. It acknowledges matching address bytes and write data. A two-byte write sets a 12-bit converter code and a 2-bit power-down mode. A read returns the same two bytes from the live registers.

The code, the mode and a one-hot load-select vector appear as registered parallel outputs. After reset the code is zero, and it stays at zero until a complete write arrives. A stop that lands on the read/write bit of the address byte sends the interface into a locked state. Only a reset clears that state. SDA is modelled as open drain: the block asserts `sda_oe` to pull the line low.

Top module: `i2c_dac_target`

## Requirements
- R1: While and after reset, `dac_code` = 0, `pd_mode` = 0, `pd_load` = 0 and `sda_oe` = 0. The code stays 0 until a complete two-byte write is received.
- R2: The target address is {5'b00011, `addr_sel`}, sent in the top seven bits of the address byte, with bit 0 = 1 for read. On a match the target pulls SDA low during the ninth clock. On any other address it leaves SDA released.
- R3: A general call byte (0x00) is not acknowledged, and neither is a 10-bit-addressing header (top five bits 11110).
- R4: Write format. Byte one bits [5:4] hold the power-down mode and bits [3:0] hold code[11:8]. Byte two holds code[7:0]. Both bytes are sent MSB first and both are acknowledged. The outputs change only once the second byte has arrived. A transfer that ends after one data byte leaves the outputs unchanged.
- R5: `pd_load` is one-hot per mode: mode 01 sets bit 0, mode 10 sets bit 1, mode 11 sets bit 2, and mode 00 gives all zeros.
- R6: A read returns {2'b00, mode, code[11:8]} and then code[7:0], each MSB first. Bits [7:6] of a written first byte have no effect and read back as zero.
- R7: When the controller does not acknowledge a read byte, the target releases SDA for the rest of the transfer. The next transaction after the stop works normally.
- R8: A stop seen while SCL is high for the eighth (read/write) bit of the address byte locks the interface. While locked it acknowledges nothing and its outputs hold. Only `rst` clears the lock.
- R9: The target changes `sda_oe` only while SCL is low. It keeps SDA released during the acknowledge slot of every read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| addr_sel | input | 2 | Strap bits forming the two address LSBs |
| sda_oe | output | 1 | 1 = pull SDA low |
| dac_code | output | CODE_W | Converter code |
| pd_mode | output | 2 | Power-down mode, 0 = normal |
| pd_load | output | 3 | One-hot output-load select for the power-down modes |

## Verification
The bench targets the write that stops after one byte: a design that commits per byte would show a half-updated code. It checks the general call and 10-bit headers, which a loose address compare would wrongly acknowledge. It ends a read with a controller NACK, because a target that keeps shifting would then hold SDA low and hang the bus. It places a stop exactly on the read/write clock of the address byte and then confirms that later writes go unanswered until reset. A design that missed that case would accept the next write. A cycle-level model of the expected outputs is compared on every quiet clock, so a spurious commit anywhere is caught.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_LOCK
  } tgt_state_e;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam int MODE_W    = 2;
  localparam int LOADS     = (1 << MODE_W) - 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high are bus conditions, never data
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_dac_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b00011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  input  logic [7:0] rd_byte0,
  input  logic [7:0] rd_byte1,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [5:0] wr_hi,
  output logic [7:0] wr_lo
);
  tgt_state_e state;
  logic [CNT_W-1:0] cnt;
  logic [7:0] sh;
  logic rw, idx, mack;
  logic [7:0] nxt_rd;

  assign nxt_rd = idx ? rd_byte0 : rd_byte1;
  assign wr_lo  = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      idx    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
      wr_hi  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (state != ST_LOCK && stop_det) begin
        // stop on the R/W clock of the address byte wedges the interface
        state  <= (state == ST_ADDR && cnt == CNT_W'(BYTE_BITS)) ? ST_LOCK : ST_IDLE;
        sda_oe <= 1'b0;
      end else if (state != ST_LOCK && start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        idx    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_BITS)) begin
              if (state == ST_ADDR) begin
                if (sh[7:1] == {ADDR_PREFIX, addr_sel}) begin
                  state  <= ST_ADDR_ACK;
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state  <= ST_WR_ACK;
                sda_oe <= 1'b1;
                if (!idx) wr_hi <= sh[5:0];
                else      wr_en <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              idx <= 1'b0;
              if (rw) begin
                state  <= ST_RD;
                sh     <= rd_byte0;
                sda_oe <= ~rd_byte0[7];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              state  <= ST_WR;
              cnt    <= '0;
              idx    <= ~idx;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_BITS)) begin
                state  <= ST_RD_ACK;
                sda_oe <= 1'b0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RD;
                cnt    <= '0;
                idx    <= ~idx;
                sh     <= nxt_rd;
                sda_oe <= ~nxt_rd[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import i2c_dac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [5:0]        wr_hi,
  input  logic [7:0]        wr_lo,
  output logic [CODE_W-1:0] dac_code,
  output logic [MODE_W-1:0] pd_mode,
  output logic [LOADS-1:0]  pd_load,
  output logic [7:0]        rd_byte0,
  output logic [7:0]        rd_byte1
);
  localparam int HI_BITS = CODE_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      pd_mode  <= '0;
    end else if (wr_en) begin
      dac_code <= {wr_hi[HI_BITS-1:0], wr_lo};
      pd_mode  <= wr_hi[5:4];
    end
  end

  for (genvar g = 0; g < LOADS; g++) begin : g_load
    always_ff @(posedge clk) begin
      if (rst)        pd_load[g] <= 1'b0;
      else if (wr_en) pd_load[g] <= (wr_hi[5:4] == MODE_W'(g + 1));
    end
  end

  always_comb begin
    rd_byte0 = '0;
    rd_byte0[5:4] = pd_mode;
    rd_byte0[HI_BITS-1:0] = dac_code[CODE_W-1:8];
    rd_byte1 = dac_code[7:0];
  end
endmodule

// File: rtl/i2c_dac_target.sv
module i2c_dac_target
  import i2c_dac_pkg::*;
#(
  parameter int         CODE_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b00011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel,
  output logic              sda_oe,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic [2:0]        pd_load
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [5:0] wr_hi;
  logic [7:0] wr_lo, rd_byte0, rd_byte1;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_byte0(rd_byte0), .rd_byte1(rd_byte1),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_hi(wr_hi), .wr_lo(wr_lo)
  );

  dac_ctrl_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .dac_code(dac_code), .pd_mode(pd_mode), .pd_load(pd_load),
    .rd_byte0(rd_byte0), .rd_byte1(rd_byte1)
  );
endmodule

// File: rtl/i2c_dac_target_chk.sv
module i2c_dac_target_chk
  import i2c_dac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        pd_mode,
  input logic [2:0]        pd_load,
  input tgt_state_e        st
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_zero_R1: assert (dac_code == '0 && pd_mode == 2'd0 && pd_load == 3'd0 && !sda_oe)
        else $error("R1 outputs not cleared by reset");
    end
  end

  assert_load_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pd_load));

  assert_load_vs_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (pd_mode == 2'd0) == (pd_load == 3'd0));

  assert_commit_on_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> !$past(scl_i, 3));

  assert_drive_on_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_i, 3));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    st == ST_LOCK |=> st == ST_LOCK);

  assert_lock_silent_R8: assert property (@(posedge clk) disable iff (rst)
    st == ST_LOCK |-> !sda_oe);

  assert_lock_holds_code_R8: assert property (@(posedge clk) disable iff (rst)
    st == ST_LOCK |=> $stable(dac_code) && $stable(pd_mode));

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !sda_oe);
endmodule

bind i2c_dac_target i2c_dac_target_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .dac_code(dac_code), .pd_mode(pd_mode), .pd_load(pd_load),
  .st(u_fsm.state)
);

// File: tb/i2c_dac_target_bench.sv
module i2c_dac_target_bench;
  localparam int HALF = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic sda_oe;
  logic [11:0] dac_code;
  logic [1:0] pd_mode;
  logic [2:0] pd_load;
  wire sda_line = m_sda & ~sda_oe;

  i2c_dac_target u_i2c_dac_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .dac_code(dac_code), .pd_mode(pd_mode), .pd_load(pd_load)
  );

  int tests = 0, fails = 0;
  bit quiet = 1'b0;
  int exp_code = 0, exp_pd = 0;
  bit mdl_locked = 1'b0;

  function automatic int load_of(int pd);
    return (pd == 0) ? 0 : (1 << (pd - 1));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && quiet) begin
      tests++;
      if (dac_code !== 12'(exp_code) || pd_mode !== 2'(exp_pd) || pd_load !== 3'(load_of(exp_pd))) begin
        fails++;
        $display("FAIL R4 per-clock act=%h/%h/%h exp=%h/%h/%h", dac_code, pd_mode, pd_load,
                 exp_code, exp_pd, load_of(exp_pd));
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    m_sda = 1'b1; scl = 1'b1; wclk(HALF);
    m_sda = 1'b0; wclk(HALF);
    scl = 1'b0; wclk(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(HALF);
    scl = 1'b1; wclk(HALF);
    m_sda = 1'b1; wclk(HALF + 10);
    quiet = 1'b1;
  endtask

  task automatic bit_clk(input bit b, output bit s, output bit oe);
    m_sda = b; wclk(HALF);
    scl = 1'b1; wclk(HALF / 2);
    s = sda_line; oe = sda_oe;
    wclk(HALF / 2);
    scl = 1'b0; wclk(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s, oe;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s, oe);
    bit_clk(1'b1, s, oe);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit oe_ack);
    bit s, oe;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s, oe);
      b[i] = s;
    end
    bit_clk(!give_ack, s, oe_ack);
  endtask

  function automatic bit addr_hit(logic [6:0] a);
    return (a == {5'b00011, addr_sel}) && !mdl_locked;
  endfunction

  task automatic write_pair(input logic [6:0] a, input logic [7:0] b0, input logic [7:0] b1,
                            input string req);
    bit ack, exp_ack;
    exp_ack = addr_hit(a);
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(ack == exp_ack, {req, " address ack"}, ack, exp_ack);
    if (ack) begin
      send_byte(b0, ack);
      check(ack, {req, " data byte 1 ack"}, ack, 1);
      send_byte(b1, ack);
      check(ack, {req, " data byte 2 ack"}, ack, 1);
      exp_code = {b0[3:0], b1};
      exp_pd   = b0[5:4];
    end
    bus_stop();
  endtask

  task automatic read_pair(input bit nack_first, input string req);
    logic [7:0] r0, r1;
    bit ack, oe, s, oe2;
    bus_start();
    send_byte({5'b00011, addr_sel, 1'b1}, ack);
    check(ack, {req, " read address ack"}, ack, 1);
    recv_byte(!nack_first, r0, oe);
    check(r0 == {2'b00, 2'(exp_pd), 4'(exp_code >> 8)}, "R6 first read byte", r0,
          {2'b00, 2'(exp_pd), 4'(exp_code >> 8)});
    check(!oe, "R9 SDA released in read ack slot", oe, 0);
    if (nack_first) begin
      bit_clk(1'b1, s, oe2);
      check(s && !oe2, "R7 SDA released after controller NACK", oe2, 0);
    end else begin
      recv_byte(1'b0, r1, oe);
      check(r1 == 8'(exp_code), "R6 second read byte", r1, 8'(exp_code));
      check(!oe, "R9 SDA released in final ack slot", oe, 0);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack, s, oe;
    wclk(10);
    check(dac_code == 0 && pd_mode == 0 && pd_load == 0 && !sda_oe, "R1 reset state",
          {dac_code, pd_mode, pd_load}, 0);
    rst = 1'b0; wclk(10);
    quiet = 1'b1;
    check(dac_code == 0, "R1 zero code after reset release", dac_code, 0);

    // R2 matching address
    write_pair(7'b0001101, 8'h0A, 8'hBC, "R2");
    check(dac_code == 12'hABC, "R2 R4 code after write", dac_code, 12'hABC);
    // R2 wrong strap value
    write_pair(7'b0001110, 8'h05, 8'h55, "R2 mismatch");
    addr_sel = 2'b10; wclk(5);
    write_pair(7'b0001110, 8'h01, 8'h23, "R2 other strap");
    check(dac_code == 12'h123, "R2 code via strap 10", dac_code, 12'h123);
    addr_sel = 2'b01; wclk(5);

    // R3 general call and 10-bit header
    bus_start(); send_byte(8'h00, ack); bus_stop();
    check(!ack, "R3 general call not acked", ack, 0);
    bus_start(); send_byte(8'hF0, ack); bus_stop();
    check(!ack, "R3 10-bit header not acked", ack, 0);

    // R4 one data byte then stop: no change
    bus_start(); send_byte({7'b0001101, 1'b0}, ack);
    send_byte(8'h3F, ack); bus_stop();
    check(dac_code == 12'h123 && pd_mode == 0, "R4 single byte leaves outputs", dac_code, 12'h123);
    // R4 one byte then repeated start, then full write
    bus_start(); send_byte({7'b0001101, 1'b0}, ack); send_byte(8'h2E, ack);
    write_pair(7'b0001101, 8'h07, 8'h89, "R4 after restart");
    check(dac_code == 12'h789, "R4 restart write", dac_code, 12'h789);

    // R5 power-down modes
    for (int m = 1; m <= 3; m++) begin
      write_pair(7'b0001101, 8'(m << 4) | 8'h04, 8'h56, "R5");
      check(pd_load == 3'(1 << (m - 1)) && pd_mode == 2'(m), "R5 load select", pd_load, 1 << (m - 1));
    end
    write_pair(7'b0001101, 8'hC0 | 8'h0F, 8'hFF, "R6 high bits");
    check(pd_load == 0 && dac_code == 12'hFFF, "R5 normal mode clears load", pd_load, 0);

    // R6 read back, R7 early NACK
    read_pair(1'b0, "R6");
    write_pair(7'b0001101, 8'h29, 8'h5A, "R6 setup");
    read_pair(1'b0, "R6 mode");
    read_pair(1'b1, "R7");
    write_pair(7'b0001101, 8'h03, 8'h33, "R7 after NACK");
    check(dac_code == 12'h333, "R7 next write works", dac_code, 12'h333);

    // R8 stop on the R/W clock of the address byte
    bus_start();
    for (int i = 6; i >= 0; i--) bit_clk(1'(7'b0001101 >> i), s, oe);
    m_sda = 1'b0; wclk(HALF);
    scl = 1'b1; wclk(HALF);
    m_sda = 1'b1; wclk(HALF + 10);
    quiet = 1'b1;
    mdl_locked = 1'b1;
    write_pair(7'b0001101, 8'h0F, 8'h00, "R8 locked");
    check(dac_code == 12'h333, "R8 locked write ignored", dac_code, 12'h333);
    rst = 1'b1; exp_code = 0; exp_pd = 0; mdl_locked = 1'b0; wclk(5);
    rst = 1'b0; wclk(5);
    check(dac_code == 0, "R8 R1 reset clears lock and code", dac_code, 0);
    write_pair(7'b0001101, 8'h0C, 8'hDE, "R8 after reset");
    check(dac_code == 12'hCDE, "R8 write after reset", dac_code, 12'hCDE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule